// File: doc/BRIEF.md
# Leveled Interrupt Priority Controller

This block keeps, for every interrupt level, a word of pending sources and a one-bit flag that marks the level as busy. Requesters post or clear a single source by giving its level and its bit index. One more input wipes every level at once. From the busy flags of the hardware levels and a software request word, the block works out an effective priority and a mask of the levels that took part. It signals that an interrupt should be taken when that priority is nonzero and strictly above the processor's current priority level. The program counter must be aligned in its two low bits, and at least one level must be busy.

Capturing the result takes two steps. A take strobe, given while the take condition holds, copies the priority and the mask into a holding stage and marks that stage full. A later commit strobe copies the held values onto the in-service mask and interrupt-identifier outputs and empties the stage. Software priorities are rebased, so the lowest software level gives priority 1. Hardware priorities equal their level number. Any busy hardware level overrides the software result.

Top module: `irq_lvl_ctl`

## Requirements
- R1: A post with level L and index i both in range sets bit i of level L's pending word, and sets bit L of `lvl_status` at the next clock edge.
- R2: A clear with level L and index i drops bit i of level L's word. Bit L of `lvl_status` falls only when that word becomes all zero.
- R3: `clr_all` zeroes every pending word and all of `lvl_status` at the next edge. It overrides a post or clear given in the same cycle.
- R4: `take_irq` is low whenever `lvl_status` is zero or `pc_lsb` is not 2'b00, even when a software request is present.
- R5: A set bit i of `sw_req`, with i from SW_LO to SW_HI (defaults 4 and 18), gives priority i-SW_LO+1 and sets bit i of `sum_mask`. The highest such bit wins.
- R6: A set bit i of `lvl_status`, with i from EXT_LO to EXT_HI (defaults 19 and 33), gives priority i and sets bit i of `sum_mask`. The highest such level wins, and it overrides any software priority. Software bits still appear in `sum_mask`.
- R7: `take_irq` is high only when `eff_prio` is nonzero and strictly greater than `cur_ipl`.
- R8: `take_stb` sampled while `take_irq` is high latches `eff_prio` and `sum_mask` and sets `hold_vld` at the next edge. `take_stb` while `take_irq` is low changes nothing.
- R9: `commit_stb` while `hold_vld` is high drives the held mask onto `isr_out` and the held priority onto `intid_out` at the next edge, and clears `hold_vld`.
- R10: A post or clear whose level is at least NUM_LEVELS, or whose index is at least WORD_W, leaves all state unchanged. It raises `req_err` for exactly the next cycle.
- R11: `commit_stb` while `hold_vld` is low leaves `isr_out`, `intid_out` and `hold_vld` unchanged.
- R12: When a post and a clear name the same level and index in one cycle, the clear wins. The bit ends at zero, and the level's status flag follows R2.
- R13: Index WORD_W-1 (63 by default) posts and clears like any other index.
- R14: While reset is asserted, `lvl_status`, `req_err`, `hold_vld`, `isr_out` and `intid_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the release is synchronised inside |
| post_vld | input | 1 | Post request strobe |
| post_lvl | input | LVL_IW (7) | Level of the post request |
| post_idx | input | IDX_IW (7) | Source index of the post request |
| clr_vld | input | 1 | Clear request strobe |
| clr_lvl | input | LVL_IW (7) | Level of the clear request |
| clr_idx | input | IDX_IW (7) | Source index of the clear request |
| clr_all | input | 1 | Empty every level |
| sw_req | input | NUM_LEVELS (64) | Software interrupt request word |
| pc_lsb | input | 2 | Low two bits of the current program counter |
| cur_ipl | input | PRIO_W (6) | Current processor priority level |
| take_stb | input | 1 | Latch the current priority and mask |
| commit_stb | input | 1 | Publish the latched priority and mask |
| lvl_status | output | NUM_LEVELS (64) | Per-level busy flags |
| req_err | output | 1 | One-cycle pulse after an out-of-range request |
| take_irq | output | 1 | Interrupt should be taken |
| eff_prio | output | PRIO_W (6) | Effective priority |
| sum_mask | output | NUM_LEVELS (64) | Mask of the levels that took part |
| hold_vld | output | 1 | Holding stage is full |
| isr_out | output | NUM_LEVELS (64) | Committed in-service mask |
| intid_out | output | PRIO_W (6) | Committed interrupt identifier |

## Verification
A pending word that keeps a stale bit shows up at the ports when the last visible source of its level is cleared. The level's flag in `lvl_status` then stays high one edge after it should have fallen, and `eff_prio` stays at that level. A wrong busy flag reaches `take_irq` and `eff_prio` in the same cycle, because the resolver is purely combinational. A holding stage in the wrong state is seen one edge after a commit strobe: `isr_out` and `intid_out` move when they should hold, or hold when they should move.

// File: rtl/irq_lvl_pkg.sv
package irq_lvl_pkg;
  localparam int DEF_NUM_LEVELS = 64;
  localparam int DEF_WORD_W     = 64;
  localparam int DEF_SW_LO      = 4;
  localparam int DEF_SW_HI      = 18;
  localparam int DEF_EXT_LO     = 19;
  localparam int DEF_EXT_HI     = 33;

  // Action of the holding stage in one cycle.
  typedef enum logic [1:0] {
    STG_IDLE   = 2'b00,
    STG_LATCH  = 2'b01,
    STG_COMMIT = 2'b10,
    STG_SWAP   = 2'b11
  } stage_op_e;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int NUM_LEVELS = 64,
  parameter int WORD_W     = 64,
  parameter int LVL_IW     = $clog2(NUM_LEVELS) + 1,
  parameter int IDX_IW     = $clog2(WORD_W) + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  post_vld,
  input  logic [LVL_IW-1:0]     post_lvl,
  input  logic [IDX_IW-1:0]     post_idx,
  input  logic                  clr_vld,
  input  logic [LVL_IW-1:0]     clr_lvl,
  input  logic [IDX_IW-1:0]     clr_idx,
  input  logic                  clr_all,
  output logic [NUM_LEVELS-1:0] status_o,
  output logic                  err_o
);
  localparam logic [LVL_IW-1:0] LVL_LIM = LVL_IW'(NUM_LEVELS);
  localparam logic [IDX_IW-1:0] IDX_LIM = IDX_IW'(WORD_W);

  logic [WORD_W-1:0]     pend_q   [NUM_LEVELS];
  logic [WORD_W-1:0]     pend_n   [NUM_LEVELS];
  logic [NUM_LEVELS-1:0] pend_en;
  logic [NUM_LEVELS-1:0] status_q, status_n;
  logic                  status_en;
  logic                  err_q, err_n;
  logic                  post_ok, clr_ok, post_bad, clr_bad;
  logic [WORD_W-1:0]     post_bits, clr_bits;

  // Request decode
  always_comb begin
    post_ok   = post_vld && (post_lvl < LVL_LIM) && (post_idx < IDX_LIM);
    clr_ok    = clr_vld  && (clr_lvl  < LVL_LIM) && (clr_idx  < IDX_LIM);
    post_bad  = post_vld && !post_ok;
    clr_bad   = clr_vld  && !clr_ok;
    post_bits = WORD_W'(1) << post_idx;
    clr_bits  = WORD_W'(1) << clr_idx;
    err_n     = post_bad || clr_bad;
  end

  // Next state of each level
  always_comb begin
    status_n  = status_q;
    status_en = clr_all || post_ok || clr_ok;
    for (int lv = 0; lv < NUM_LEVELS; lv++) begin
      logic hit_p, hit_c;
      logic [WORD_W-1:0] w;
      hit_p = post_ok && (post_lvl == LVL_IW'(lv));
      hit_c = clr_ok  && (clr_lvl  == LVL_IW'(lv));
      w = pend_q[lv];
      if (hit_p) w = w | post_bits;
      if (hit_c) w = w & ~clr_bits;
      if (clr_all) w = '0;
      pend_n[lv]  = w;
      pend_en[lv] = clr_all || hit_p || hit_c;
      if (hit_p) status_n[lv] = 1'b1;
      if (hit_c && (w == '0)) status_n[lv] = 1'b0;
      if (clr_all) status_n[lv] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int lv = 0; lv < NUM_LEVELS; lv++) pend_q[lv] <= '0;
      status_q <= '0;
      err_q    <= 1'b0;
    end else begin
      for (int lv = 0; lv < NUM_LEVELS; lv++)
        if (pend_en[lv]) pend_q[lv] <= pend_n[lv];
      if (status_en) status_q <= status_n;
      err_q <= err_n;
    end
  end

  assign status_o = status_q;
  assign err_o    = err_q;

  // The flag of each level agrees with its pending word (R1, R2).
  for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_chk
    a_r2_flag_matches_word: assert property (@(posedge clk) disable iff (!rst_n)
      status_q[g] == (pend_q[g] != '0));
  end

  a_r3_clear_all_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (status_q == '0));

  a_r10_bad_req_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (post_bad || clr_bad) |=> err_q);

  a_r10_bad_req_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    ((post_bad || !post_vld) && (clr_bad || !clr_vld) && !clr_all) |=> $stable(status_q));
endmodule

// File: rtl/irq_prio_resolve.sv
module irq_prio_resolve #(
  parameter int NUM_LEVELS = 64,
  parameter int SW_LO      = 4,
  parameter int SW_HI      = 18,
  parameter int EXT_LO     = 19,
  parameter int EXT_HI     = 33,
  parameter int PRIO_W     = $clog2(NUM_LEVELS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_LEVELS-1:0] status_i,
  input  logic [NUM_LEVELS-1:0] sw_req_i,
  input  logic [1:0]            pc_lsb_i,
  input  logic [PRIO_W-1:0]     cur_ipl_i,
  output logic [PRIO_W-1:0]     prio_o,
  output logic [NUM_LEVELS-1:0] mask_o,
  output logic                  take_o
);
  logic [PRIO_W-1:0]     sw_prio, ext_prio;
  logic                  ext_any, gate_ok;
  logic [NUM_LEVELS-1:0] ext_range;

  always_comb begin
    sw_prio   = '0;
    ext_prio  = '0;
    ext_any   = 1'b0;
    mask_o    = '0;
    ext_range = '0;
    // Software levels are rebased so the lowest gives priority 1.
    for (int i = SW_LO; i <= SW_HI; i++) begin
      if (sw_req_i[i]) begin
        sw_prio   = PRIO_W'(i - SW_LO + 1);
        mask_o[i] = 1'b1;
      end
    end
    // Hardware levels carry their own number as priority.
    for (int i = EXT_LO; i <= EXT_HI; i++) begin
      ext_range[i] = 1'b1;
      if (status_i[i]) begin
        ext_prio  = PRIO_W'(i);
        ext_any   = 1'b1;
        mask_o[i] = 1'b1;
      end
    end
    prio_o  = ext_any ? ext_prio : sw_prio;
    gate_ok = (status_i != '0) && (pc_lsb_i == 2'b00);
    take_o  = gate_ok && (prio_o != '0) && (prio_o > cur_ipl_i);
  end

  a_r4_idle_no_take: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_i == '0) || (pc_lsb_i != 2'b00)) |-> !take_o);

  a_r7_take_above_ipl: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (prio_o > cur_ipl_i));

  a_r6_ext_overrides: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_i & ext_range) != '0) |-> (prio_o >= PRIO_W'(EXT_LO)));
endmodule

// File: rtl/irq_isr_stage.sv
module irq_isr_stage
  import irq_lvl_pkg::*;
#(
  parameter int NUM_LEVELS = 64,
  parameter int PRIO_W     = $clog2(NUM_LEVELS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  take_stb,
  input  logic                  take_ok,
  input  logic [PRIO_W-1:0]     prio_i,
  input  logic [NUM_LEVELS-1:0] mask_i,
  input  logic                  commit_stb,
  output logic                  hold_vld_o,
  output logic [NUM_LEVELS-1:0] isr_o,
  output logic [PRIO_W-1:0]     intid_o
);
  logic [PRIO_W-1:0]     hold_prio_q;
  logic [NUM_LEVELS-1:0] hold_mask_q;
  logic                  hold_vld_q, hold_vld_n;
  logic [NUM_LEVELS-1:0] isr_q;
  logic [PRIO_W-1:0]     intid_q;
  logic                  do_latch, do_commit;
  stage_op_e             op;

  always_comb begin
    do_latch  = take_stb && take_ok;
    do_commit = commit_stb && hold_vld_q;
    op        = stage_op_e'({do_commit, do_latch});
    unique case (op)
      STG_LATCH, STG_SWAP: hold_vld_n = 1'b1;
      STG_COMMIT:          hold_vld_n = 1'b0;
      default:             hold_vld_n = hold_vld_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_prio_q <= '0;
      hold_mask_q <= '0;
      hold_vld_q  <= 1'b0;
      isr_q       <= '0;
      intid_q     <= '0;
    end else begin
      hold_vld_q <= hold_vld_n;
      if (do_latch) begin
        hold_prio_q <= prio_i;
        hold_mask_q <= mask_i;
      end
      if (do_commit) begin
        isr_q   <= hold_mask_q;
        intid_q <= hold_prio_q;
      end
    end
  end

  assign hold_vld_o = hold_vld_q;
  assign isr_o      = isr_q;
  assign intid_o    = intid_q;

  a_r8_latch_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (take_stb && take_ok) |=> hold_vld_q);

  a_r9_commit_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_stb && hold_vld_q && !(take_stb && take_ok)) |=> !hold_vld_q);

  a_r11_idle_commit_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_vld_q) |=> ($stable(isr_q) && $stable(intid_q)));
endmodule

// File: rtl/irq_lvl_ctl.sv
module irq_lvl_ctl
  import irq_lvl_pkg::*;
#(
  parameter int NUM_LEVELS = DEF_NUM_LEVELS,
  parameter int WORD_W     = DEF_WORD_W,
  parameter int SW_LO      = DEF_SW_LO,
  parameter int SW_HI      = DEF_SW_HI,
  parameter int EXT_LO     = DEF_EXT_LO,
  parameter int EXT_HI     = DEF_EXT_HI,
  parameter int PRIO_W     = $clog2(NUM_LEVELS),
  parameter int LVL_IW     = $clog2(NUM_LEVELS) + 1,
  parameter int IDX_IW     = $clog2(WORD_W) + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  post_vld,
  input  logic [LVL_IW-1:0]     post_lvl,
  input  logic [IDX_IW-1:0]     post_idx,
  input  logic                  clr_vld,
  input  logic [LVL_IW-1:0]     clr_lvl,
  input  logic [IDX_IW-1:0]     clr_idx,
  input  logic                  clr_all,
  input  logic [NUM_LEVELS-1:0] sw_req,
  input  logic [1:0]            pc_lsb,
  input  logic [PRIO_W-1:0]     cur_ipl,
  input  logic                  take_stb,
  input  logic                  commit_stb,
  output logic [NUM_LEVELS-1:0] lvl_status,
  output logic                  req_err,
  output logic                  take_irq,
  output logic [PRIO_W-1:0]     eff_prio,
  output logic [NUM_LEVELS-1:0] sum_mask,
  output logic                  hold_vld,
  output logic [NUM_LEVELS-1:0] isr_out,
  output logic [PRIO_W-1:0]     intid_out
);
  logic rst_n_s;

  irq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  irq_pend_bank #(
    .NUM_LEVELS (NUM_LEVELS),
    .WORD_W     (WORD_W),
    .LVL_IW     (LVL_IW),
    .IDX_IW     (IDX_IW)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .post_vld (post_vld),
    .post_lvl (post_lvl),
    .post_idx (post_idx),
    .clr_vld  (clr_vld),
    .clr_lvl  (clr_lvl),
    .clr_idx  (clr_idx),
    .clr_all  (clr_all),
    .status_o (lvl_status),
    .err_o    (req_err)
  );

  irq_prio_resolve #(
    .NUM_LEVELS (NUM_LEVELS),
    .SW_LO      (SW_LO),
    .SW_HI      (SW_HI),
    .EXT_LO     (EXT_LO),
    .EXT_HI     (EXT_HI),
    .PRIO_W     (PRIO_W)
  ) u_resolve (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .status_i  (lvl_status),
    .sw_req_i  (sw_req),
    .pc_lsb_i  (pc_lsb),
    .cur_ipl_i (cur_ipl),
    .prio_o    (eff_prio),
    .mask_o    (sum_mask),
    .take_o    (take_irq)
  );

  irq_isr_stage #(
    .NUM_LEVELS (NUM_LEVELS),
    .PRIO_W     (PRIO_W)
  ) u_stage (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .take_stb   (take_stb),
    .take_ok    (take_irq),
    .prio_i     (eff_prio),
    .mask_i     (sum_mask),
    .commit_stb (commit_stb),
    .hold_vld_o (hold_vld),
    .isr_o      (isr_out),
    .intid_o    (intid_out)
  );

  a_r14_reset_clean: assert property (@(posedge clk)
    !rst_n_s |-> (lvl_status == '0 && !hold_vld && isr_out == '0));
endmodule

// File: tb/irq_lvl_ctl_tb.sv
module irq_lvl_ctl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        post_vld, clr_vld, clr_all, take_stb, commit_stb;
  logic [6:0]  post_lvl, post_idx, clr_lvl, clr_idx;
  logic [63:0] sw_req;
  logic [1:0]  pc_lsb;
  logic [5:0]  cur_ipl;
  logic [63:0] lvl_status, sum_mask, isr_out;
  logic        req_err, take_irq, hold_vld;
  logic [5:0]  eff_prio, intid_out;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  irq_lvl_ctl u_dut (
    .clk(clk), .rst_n(rst_n),
    .post_vld(post_vld), .post_lvl(post_lvl), .post_idx(post_idx),
    .clr_vld(clr_vld), .clr_lvl(clr_lvl), .clr_idx(clr_idx),
    .clr_all(clr_all), .sw_req(sw_req), .pc_lsb(pc_lsb), .cur_ipl(cur_ipl),
    .take_stb(take_stb), .commit_stb(commit_stb),
    .lvl_status(lvl_status), .req_err(req_err), .take_irq(take_irq),
    .eff_prio(eff_prio), .sum_mask(sum_mask), .hold_vld(hold_vld),
    .isr_out(isr_out), .intid_out(intid_out)
  );

  typedef struct packed {
    logic        pv; logic [6:0] pl; logic [6:0] pi;
    logic        cv; logic [6:0] cl; logic [6:0] ci;
    logic        ca; logic [63:0] sw; logic [5:0] ipl; logic [1:0] pcl;
    logic [63:0] est; logic eerr; logic etake; logic [5:0] eprio; logic [63:0] emask;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    // R14 baseline: nothing pending
    '{1'b0,7'd0, 7'd0, 1'b0,7'd0, 7'd0,1'b0,64'h0,    6'd0, 2'd0,64'h0,          1'b0,1'b0,6'd0, 64'h0},
    // R1 post 20:3
    '{1'b1,7'd20,7'd3, 1'b0,7'd0, 7'd0,1'b0,64'h0,    6'd0, 2'd0,64'h10_0000,    1'b0,1'b1,6'd20,64'h10_0000},
    // R13 post 20:63, R7 ipl equal -> no take
    '{1'b1,7'd20,7'd63,1'b0,7'd0, 7'd0,1'b0,64'h0,    6'd20,2'd0,64'h10_0000,    1'b0,1'b0,6'd20,64'h10_0000},
    // R2 clear 20:3, bit 63 keeps level busy
    '{1'b0,7'd0, 7'd0, 1'b1,7'd20,7'd3,1'b0,64'h0,    6'd0, 2'd0,64'h10_0000,    1'b0,1'b1,6'd20,64'h10_0000},
    // R13 R2 clear 20:63 empties level
    '{1'b0,7'd0, 7'd0, 1'b1,7'd20,7'd63,1'b0,64'h0,   6'd0, 2'd0,64'h0,          1'b0,1'b0,6'd0, 64'h0},
    // R4 software only, status zero -> no take; R5 prio 10-4+1
    '{1'b0,7'd0, 7'd0, 1'b0,7'd0, 7'd0,1'b0,64'h400,  6'd0, 2'd0,64'h0,          1'b0,1'b0,6'd7, 64'h400},
    // R5 software level 5 busy flag lets take through
    '{1'b1,7'd5, 7'd0, 1'b0,7'd0, 7'd0,1'b0,64'h400,  6'd0, 2'd0,64'h20,         1'b0,1'b1,6'd7, 64'h400},
    // R5 highest software bit 18 -> 15
    '{1'b0,7'd0, 7'd0, 1'b0,7'd0, 7'd0,1'b0,64'h40400,6'd14,2'd0,64'h20,         1'b0,1'b1,6'd15,64'h40400},
    // R4 unaligned pc
    '{1'b0,7'd0, 7'd0, 1'b0,7'd0, 7'd0,1'b0,64'h40400,6'd14,2'd2,64'h20,         1'b0,1'b0,6'd15,64'h40400},
    // R6 hardware 33 overrides software
    '{1'b1,7'd33,7'd1, 1'b0,7'd0, 7'd0,1'b0,64'h40400,6'd14,2'd0,64'h2_0000_0020,1'b0,1'b1,6'd33,64'h2_0004_0400},
    // R6 lower hardware 19 does not win
    '{1'b1,7'd19,7'd0, 1'b0,7'd0, 7'd0,1'b0,64'h40400,6'd14,2'd0,64'h2_0008_0020,1'b0,1'b1,6'd33,64'h2_000C_0400},
    // R10 level out of range
    '{1'b1,7'd64,7'd0, 1'b0,7'd0, 7'd0,1'b0,64'h40400,6'd14,2'd0,64'h2_0008_0020,1'b1,1'b1,6'd33,64'h2_000C_0400},
    // R10 index out of range
    '{1'b1,7'd21,7'd64,1'b0,7'd0, 7'd0,1'b0,64'h40400,6'd14,2'd0,64'h2_0008_0020,1'b1,1'b1,6'd33,64'h2_000C_0400},
    // R12 post and clear same bit, clear wins; R10 pulse gone
    '{1'b1,7'd22,7'd7, 1'b1,7'd22,7'd7,1'b0,64'h40400,6'd14,2'd0,64'h2_0008_0020,1'b0,1'b1,6'd33,64'h2_000C_0400},
    // R10 bad clear
    '{1'b0,7'd0, 7'd0, 1'b1,7'd70,7'd0,1'b0,64'h40400,6'd14,2'd0,64'h2_0008_0020,1'b1,1'b1,6'd33,64'h2_000C_0400},
    // R3 clear-all beats post
    '{1'b1,7'd40,7'd0, 1'b0,7'd0, 7'd0,1'b1,64'h0,    6'd0, 2'd0,64'h0,          1'b0,1'b0,6'd0, 64'h0}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    post_vld = 0; post_lvl = 0; post_idx = 0;
    clr_vld = 0; clr_lvl = 0; clr_idx = 0; clr_all = 0;
    take_stb = 0; commit_stb = 0;
  endtask

  initial begin
    idle_inputs();
    sw_req = '0; pc_lsb = 0; cur_ipl = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R14 status", lvl_status, 64'h0);
    chk("R14 hold", {63'h0, hold_vld}, 64'h0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R14 err", {63'h0, req_err}, 64'h0);
    chk("R14 isr", isr_out, 64'h0);
    chk("R14 intid", {58'h0, intid_out}, 64'h0);

    for (int k = 0; k < NV; k++) begin
      post_vld = VECS[k].pv; post_lvl = VECS[k].pl; post_idx = VECS[k].pi;
      clr_vld = VECS[k].cv; clr_lvl = VECS[k].cl; clr_idx = VECS[k].ci;
      clr_all = VECS[k].ca; sw_req = VECS[k].sw; cur_ipl = VECS[k].ipl;
      pc_lsb = VECS[k].pcl;
      @(negedge clk);
      idle_inputs();
      chk($sformatf("R1/R2/R3 status v%0d", k), lvl_status, VECS[k].est);
      chk($sformatf("R10 err v%0d", k), {63'h0, req_err}, {63'h0, VECS[k].eerr});
      chk($sformatf("R4/R7 take v%0d", k), {63'h0, take_irq}, {63'h0, VECS[k].etake});
      chk($sformatf("R5/R6 prio v%0d", k), {58'h0, eff_prio}, {58'h0, VECS[k].eprio});
      chk($sformatf("R5/R6 mask v%0d", k), sum_mask, VECS[k].emask);
    end

    // R11: commit with empty stage
    sw_req = '0; cur_ipl = 0; pc_lsb = 0;
    commit_stb = 1; @(negedge clk); commit_stb = 0;
    chk("R11 isr unchanged", isr_out, 64'h0);
    chk("R11 hold stays low", {63'h0, hold_vld}, 64'h0);

    // R8: latch
    post_vld = 1; post_lvl = 25; post_idx = 2; @(negedge clk); idle_inputs();
    chk("R1 take ready", {63'h0, take_irq}, 64'h1);
    take_stb = 1; @(negedge clk); take_stb = 0;
    chk("R8 hold set", {63'h0, hold_vld}, 64'h1);
    chk("R8 isr not yet", isr_out, 64'h0);

    // R9: commit
    commit_stb = 1; @(negedge clk); commit_stb = 0;
    chk("R9 isr", isr_out, 64'h1 << 25);
    chk("R9 intid", {58'h0, intid_out}, 64'd25);
    chk("R9 hold cleared", {63'h0, hold_vld}, 64'h0);

    // R11: second commit with nothing held, after a new level is busy
    post_vld = 1; post_lvl = 30; post_idx = 0; @(negedge clk); idle_inputs();
    commit_stb = 1; @(negedge clk); commit_stb = 0;
    chk("R11 isr kept", isr_out, 64'h1 << 25);
    chk("R11 intid kept", {58'h0, intid_out}, 64'd25);

    // R8: take strobe while take is low
    cur_ipl = 6'd40;
    take_stb = 1; @(negedge clk); take_stb = 0;
    chk("R8 no latch when low", {63'h0, hold_vld}, 64'h0);
    commit_stb = 1; @(negedge clk); commit_stb = 0;
    chk("R8 nothing to commit", {58'h0, intid_out}, 64'd25);

    // R14: reset mid-run
    rst_n = 0; #1;
    chk("R14 async status", lvl_status, 64'h0);
    chk("R14 async isr", isr_out, 64'h0);
    @(negedge clk); rst_n = 1;
    repeat (3) @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule